// File: doc/BRIEF.md
# Sinc Decimation Filter with Averaging Integrator

This block turns the one-bit stream of a sigma-delta modulator into signed multi-bit samples. Each accepted modulator bit is mapped to +1 or -1. It then passes through a cascaded integrator-comb sinc filter of selectable order, which decimates by the filter ratio. A second stage adds up a programmable number of consecutive settled filter outputs to form one conversion result.

Software picks the order, the two ratios and single or continuous operation, enables the block and gives a start pulse. The block counts the settling outputs it must throw away. It reports each finished result with an end-of-conversion flag, which a read strobe clears, and with an overrun flag when a result lands on top of an unread one. A single interrupt line combines both flags under their own enables.

Top module: `sinc_decimator`

## Requirements
- R1: After reset `eoc`, `ovr` and `irq` are 0 and `result` is 0.
- R2: A conversion starts only on a `start` pulse while `en` is 1. A pulse with `en` at 0 is ignored, and `en` at 1 with no pulse starts nothing.
- R3: For order code p in 1..5 (`ord_sel` = p), the first result after a start is flagged right after accepted bit number fosr*(iosr-1+p)+p.
- R4: Order code 0 selects fast-sinc: the first result is flagged after bit fosr*(iosr+3)+2, and its value is twice the order-2 value of R5.
- R5: A modulator 1 counts +1 and a 0 counts -1. Filter output m (m = 1, 2, ...) is the input convolved with p cascaded length-fosr boxcars, evaluated at bit m*fosr. Outputs 1..p-1 (1..3 for fast-sinc) are discarded. `result` is the low 32 bits of the sum of the next iosr outputs, and it holds its value between results.
- R6: With `cont` at 1, later results follow every fosr*iosr accepted bits, each summing the next iosr filter outputs.
- R7: With `cont` at 0, the block returns to idle after one result, and further bits produce no result.
- R8: `eoc` is set when a result completes and is cleared by a one-cycle `rd` pulse.
- R9: `ovr` is set when a result completes while `eoc` is still set and not being read. A one-cycle `ovr_clr` pulse clears it.
- R10: `irq` is 1 exactly when (`eoc` and `eoc_ie`) or (`ovr` and `ovr_ie`).
- R11: Driving `en` to 0 stops a running conversion, so that conversion never yields a result.
- R12: Only cycles with `bit_valid` at 1 advance the filter. Idle cycles between bits change neither the timing nor the value.
- R13: The ratio fields carry the ratio minus one: `fosr_m1` = fosr-1 (fosr 1..1024) and `iosr_m1` = iosr-1 (iosr 1..256).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Filter enable; 0 stops conversion |
| start | input | 1 | One-cycle conversion start pulse |
| cont | input | 1 | 1 = continuous, 0 = single conversion |
| ord_sel | input | 3 | 0 = fast-sinc, 1..5 = sinc order |
| fosr_m1 | input | 10 | Filter oversampling ratio minus one |
| iosr_m1 | input | 8 | Integrator oversampling ratio minus one |
| bit_in | input | 1 | Modulator output bit |
| bit_valid | input | 1 | Qualifies `bit_in` |
| rd | input | 1 | Result read strobe, clears `eoc` |
| ovr_clr | input | 1 | Overrun clear strobe |
| eoc_ie | input | 1 | End-of-conversion interrupt enable |
| ovr_ie | input | 1 | Overrun interrupt enable |
| result | output | 32 | Signed conversion result |
| eoc | output | 1 | End-of-conversion flag |
| ovr | output | 1 | Overrun flag |
| irq | output | 1 | Combined interrupt |

## Verification
The bench builds the block with its default parameters: 10-bit filter ratio, 8-bit integrator ratio, orders up to 5 and 52-bit internal arithmetic. This means the wrap-around integrators are the full production width. It then programs small run-time ratios (1 to 8), so every order and the fast-sinc mode reach a result within about 70 modulator bits. That makes the exact settling bit counts, the continuous period and the overrun ordering cheap to reach for each order code. The expected values come from direct convolution with stacked boxcars, not from an integrator-comb model.

// File: rtl/sdf_pkg.sv
package sdf_pkg;
  typedef logic [2:0] ord_t;

  localparam ord_t ORD_FAST = 3'd0;

  typedef enum logic {ST_IDLE, ST_RUN} sdf_state_e;

  // Number of cascaded stages actually used for an order code.
  function automatic ord_t eff_order(input ord_t code, input ord_t max_ord);
    if (code == ORD_FAST) return 3'd2;
    if (code > max_ord)   return max_ord;
    return code;
  endfunction

  // Decimated outputs discarded before the integrator starts summing.
  function automatic ord_t settle_skip(input ord_t code, input ord_t max_ord);
    if (code == ORD_FAST) return 3'd3;
    return eff_order(code, max_ord) - 3'd1;
  endfunction
endpackage

// File: rtl/sdf_integ_chain.sv
module sdf_integ_chain #(
  parameter int ORD_MAX = 5,
  parameter int ACC_W   = 52
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clr,
  input  logic                    step,
  input  logic signed [ACC_W-1:0] x,
  input  sdf_pkg::ord_t           p,
  output logic signed [ACC_W-1:0] tap_next
);
  // stg[0] registers the mapped input; stg[j] lags stage j-1 by one bit
  logic signed [ACC_W-1:0] stg [ORD_MAX+1];
  logic signed [ACC_W-1:0] nxt [ORD_MAX+1];

  assign nxt[0] = x;
  for (genvar j = 1; j <= ORD_MAX; j++) begin : g_stage
    assign nxt[j] = stg[j] + stg[j-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int j = 0; j <= ORD_MAX; j++) stg[j] <= '0;
    end else if (clr) begin
      for (int j = 0; j <= ORD_MAX; j++) stg[j] <= '0;
    end else if (step) begin
      for (int j = 0; j <= ORD_MAX; j++) stg[j] <= nxt[j];
    end
  end

  always_comb begin
    tap_next = nxt[1];
    for (int j = 1; j <= ORD_MAX; j++)
      if (p == sdf_pkg::ord_t'(j)) tap_next = nxt[j];
  end
endmodule

// File: rtl/sdf_comb_bank.sv
module sdf_comb_bank #(
  parameter int ORD_MAX = 5,
  parameter int ACC_W   = 52
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clr,
  input  logic                    dec,
  input  sdf_pkg::ord_t           p,
  input  logic signed [ACC_W-1:0] din,
  output logic signed [ACC_W-1:0] dout
);
  logic signed [ACC_W-1:0] c   [ORD_MAX+1];
  logic signed [ACC_W-1:0] dly [ORD_MAX];

  assign c[0] = din;
  for (genvar j = 1; j <= ORD_MAX; j++) begin : g_comb
    assign c[j] = c[j-1] - dly[j-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int j = 0; j < ORD_MAX; j++) dly[j] <= '0;
    end else if (clr) begin
      for (int j = 0; j < ORD_MAX; j++) dly[j] <= '0;
    end else if (dec) begin
      for (int j = 0; j < ORD_MAX; j++) dly[j] <= c[j];
    end
  end

  always_comb begin
    dout = c[1];
    for (int j = 1; j <= ORD_MAX; j++)
      if (p == sdf_pkg::ord_t'(j)) dout = c[j];
  end
endmodule

// File: rtl/sdf_sequencer.sv
module sdf_sequencer #(
  parameter int ORD_MAX = 5,
  parameter int FOSR_W  = 10,
  parameter int IOSR_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              start,
  input  logic              cont,
  input  sdf_pkg::ord_t     ord_sel,
  input  logic [FOSR_W-1:0] fosr_m1,
  input  logic [IOSR_W-1:0] iosr_m1,
  input  logic              bit_valid,
  output logic              busy,
  output logic              clr,
  output logic              step,
  output logic              dec,
  output logic              keep,
  output logic              last,
  output logic              fast,
  output logic              cont_q,
  output sdf_pkg::ord_t     p_eff
);
  import sdf_pkg::*;
  localparam int   PH_W  = FOSR_W + 1;
  localparam ord_t OMAX  = ord_t'(ORD_MAX);

  sdf_state_e        state;
  logic [PH_W-1:0]   phase;
  ord_t              skip;
  ord_t              ord_q;
  logic [IOSR_W-1:0] icnt;
  logic [FOSR_W-1:0] fosr_q;
  logic [IOSR_W-1:0] iosr_q;

  assign busy  = (state == ST_RUN);
  assign clr   = !busy && en && start;
  assign step  = busy && bit_valid;
  assign dec   = step && (phase == '0);
  assign keep  = dec && (skip == '0);
  assign last  = keep && (icnt == '0);
  assign fast  = (ord_q == ORD_FAST);
  assign p_eff = eff_order(ord_q, OMAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      phase  <= '0;
      skip   <= '0;
      ord_q  <= 3'd1;
      icnt   <= '0;
      fosr_q <= '0;
      iosr_q <= '0;
      cont_q <= 1'b0;
    end else if (!en) begin
      state <= ST_IDLE;
    end else if (clr) begin
      state  <= ST_RUN;
      ord_q  <= ord_sel;
      fosr_q <= fosr_m1;
      iosr_q <= iosr_m1;
      cont_q <= cont;
      // first decimation lands on bit fosr + p
      phase  <= PH_W'(fosr_m1) + PH_W'(eff_order(ord_sel, OMAX));
      skip   <= settle_skip(ord_sel, OMAX);
      icnt   <= iosr_m1;
    end else if (step) begin
      phase <= (phase == '0) ? PH_W'(fosr_q) : phase - 1'b1;
      if (dec) begin
        if (skip != '0) begin
          skip <= skip - 3'd1;
        end else if (icnt == '0) begin
          icnt <= iosr_q;
          if (!cont_q) state <= ST_IDLE;
        end else begin
          icnt <= icnt - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/sdf_accum.sv
module sdf_accum #(
  parameter int ACC_W = 52,
  parameter int RES_W = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clr,
  input  logic                    keep,
  input  logic                    last,
  input  logic                    fast,
  input  logic signed [ACC_W-1:0] y,
  output logic [RES_W-1:0]        result,
  output logic                    done
);
  logic signed [ACC_W-1:0] acc;
  logic signed [ACC_W-1:0] y_g;
  logic signed [ACC_W-1:0] sum;

  assign y_g  = fast ? (y <<< 1) : y;
  assign sum  = acc + y_g;
  assign done = last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc    <= '0;
      result <= '0;
    end else if (clr) begin
      acc <= '0;
    end else if (keep) begin
      acc <= last ? '0 : sum;
      if (last) result <= sum[RES_W-1:0];
    end
  end
endmodule

// File: rtl/sinc_decimator.sv
module sinc_decimator #(
  parameter int ORD_MAX = 5,
  parameter int FOSR_W  = 10,
  parameter int IOSR_W  = 8,
  parameter int RES_W   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              start,
  input  logic              cont,
  input  logic [2:0]        ord_sel,
  input  logic [FOSR_W-1:0] fosr_m1,
  input  logic [IOSR_W-1:0] iosr_m1,
  input  logic              bit_in,
  input  logic              bit_valid,
  input  logic              rd,
  input  logic              ovr_clr,
  input  logic              eoc_ie,
  input  logic              ovr_ie,
  output logic [RES_W-1:0]  result,
  output logic              eoc,
  output logic              ovr,
  output logic              irq
);
  localparam int ACC_W = ORD_MAX * FOSR_W + 2;

  logic busy, clr, step, dec, keep, last, fast, run_cont, done;
  sdf_pkg::ord_t p_eff;
  logic signed [ACC_W-1:0] x_lvl, tap, y;

  assign x_lvl = bit_in ? ACC_W'(1) : {ACC_W{1'b1}};

  sdf_sequencer #(.ORD_MAX(ORD_MAX), .FOSR_W(FOSR_W), .IOSR_W(IOSR_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .en(en), .start(start), .cont(cont),
    .ord_sel(ord_sel), .fosr_m1(fosr_m1), .iosr_m1(iosr_m1),
    .bit_valid(bit_valid), .busy(busy), .clr(clr), .step(step), .dec(dec),
    .keep(keep), .last(last), .fast(fast), .cont_q(run_cont), .p_eff(p_eff)
  );

  sdf_integ_chain #(.ORD_MAX(ORD_MAX), .ACC_W(ACC_W)) u_integ (
    .clk(clk), .rst_n(rst_n), .clr(clr), .step(step), .x(x_lvl),
    .p(p_eff), .tap_next(tap)
  );

  sdf_comb_bank #(.ORD_MAX(ORD_MAX), .ACC_W(ACC_W)) u_comb (
    .clk(clk), .rst_n(rst_n), .clr(clr), .dec(dec), .p(p_eff),
    .din(tap), .dout(y)
  );

  sdf_accum #(.ACC_W(ACC_W), .RES_W(RES_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .clr(clr), .keep(keep), .last(last),
    .fast(fast), .y(y), .result(result), .done(done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eoc <= 1'b0;
      ovr <= 1'b0;
    end else begin
      if (done)    eoc <= 1'b1;
      else if (rd) eoc <= 1'b0;
      if (done && eoc && !rd) ovr <= 1'b1;
      else if (ovr_clr)       ovr <= 1'b0;
    end
  end

  assign irq = (eoc && eoc_ie) || (ovr && ovr_ie);
endmodule

// File: rtl/sdf_checker.sv
module sdf_checker #(
  parameter int RES_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic             start,
  input logic             bit_valid,
  input logic             rd,
  input logic             ovr_clr,
  input logic             eoc,
  input logic             ovr,
  input logic             irq,
  input logic [RES_W-1:0] result,
  input logic             busy,
  input logic             done,
  input logic             dec,
  input logic             run_cont
);
  assert_start_needs_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(en && start));
  assert_result_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !done |=> $stable(result));
  assert_single_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done && !run_cont |=> !busy);
  assert_eoc_on_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> eoc);
  assert_rd_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rd && !done |=> !eoc);
  assert_ovr_on_unread_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done && eoc && !rd |=> ovr);
  assert_ovr_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_clr && !(done && eoc && !rd) |=> !ovr);
  assert_irq_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !eoc && !ovr |-> !irq);
  assert_stop_on_disable_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !busy);
  assert_dec_gated_R12: assert property (@(posedge clk) disable iff (!rst_n)
    dec |-> bit_valid && busy);
endmodule

bind sinc_decimator sdf_checker #(.RES_W(RES_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .start(start), .bit_valid(bit_valid),
  .rd(rd), .ovr_clr(ovr_clr), .eoc(eoc), .ovr(ovr), .irq(irq),
  .result(result), .busy(busy), .done(done), .dec(dec), .run_cont(run_cont)
);

// File: tb/test_sinc_decimator.sv
module test_sinc_decimator;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0, start = 1'b0, cont = 1'b0;
  logic [2:0] ord_sel = 3'd1;
  logic [9:0] fosr_m1 = '0;
  logic [7:0] iosr_m1 = '0;
  logic bit_in = 1'b0, bit_valid = 1'b0, rd = 1'b0, ovr_clr = 1'b0;
  logic eoc_ie = 1'b0, ovr_ie = 1'b0;
  logic [31:0] result;
  logic eoc, ovr, irq;

  int checks = 0;
  int errors = 0;
  logic bits [1:400];

  // ord code, fosr, iosr, bit count of first result
  localparam int VEC [7][4] = '{
    '{1, 4, 3, 13}, '{2, 3, 2, 11}, '{3, 2, 4, 15}, '{5, 4, 2, 29},
    '{0, 3, 2, 17}, '{4, 1, 1, 8},  '{2, 8, 1, 18}
  };

  always #2 clk = ~clk;

  sinc_decimator i_sinc_decimator (
    .clk(clk), .rst_n(rst_n), .en(en), .start(start), .cont(cont),
    .ord_sel(ord_sel), .fosr_m1(fosr_m1), .iosr_m1(iosr_m1),
    .bit_in(bit_in), .bit_valid(bit_valid), .rd(rd), .ovr_clr(ovr_clr),
    .eoc_ie(eoc_ie), .ovr_ie(ovr_ie), .result(result), .eoc(eoc),
    .ovr(ovr), .irq(irq)
  );

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic fill(input int seed);
    logic [15:0] l = 16'(seed * 16'h1d3 + 1);
    for (int n = 1; n <= 400; n++) begin
      l = (l >> 1) ^ (l[0] ? 16'hB400 : 16'h0000);
      bits[n] = l[0];
    end
  endtask

  // direct convolution with p stacked boxcars of length fosr
  function automatic longint filt_out(input int p, input int fosr, input int m);
    longint h [0:63];
    longint t [0:63];
    int len = fosr;
    longint y = 0;
    int n;
    for (int i = 0; i < 64; i++) h[i] = (i < fosr) ? 1 : 0;
    for (int r = 2; r <= p; r++) begin
      for (int i = 0; i < 64; i++) begin
        t[i] = 0;
        for (int k = 0; k < fosr; k++) if (i - k >= 0) t[i] += h[i-k];
      end
      for (int i = 0; i < 64; i++) h[i] = t[i];
      len += fosr - 1;
    end
    for (int j = 0; j < len; j++) begin
      n = m * fosr - j;
      if (n >= 1) y += h[j] * (bits[n] ? 1 : -1);
    end
    return y;
  endfunction

  function automatic longint model_res(input int code, input int fosr,
                                       input int iosr, input int m0);
    int p = (code == 0) ? 2 : code;
    longint g = (code == 0) ? 2 : 1;
    longint s = 0;
    logic [31:0] tr;
    for (int m = m0; m < m0 + iosr; m++) s += g * filt_out(p, fosr, m);
    tr = s[31:0];
    return longint'($signed(tr));
  endfunction

  task automatic drive_bit(input logic b, input int gap);
    @(negedge clk); bit_valid = 1'b1; bit_in = b;
    @(negedge clk); bit_valid = 1'b0; bit_in = ~b;
    repeat (gap) @(negedge clk);
  endtask

  task automatic do_start(input int code, input int fosr, input int iosr, input logic c);
    @(negedge clk);
    ord_sel = 3'(code); fosr_m1 = 10'(fosr - 1); iosr_m1 = 8'(iosr - 1);
    cont = c; en = 1'b1; start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic pulse_rd();
    @(negedge clk); rd = 1'b1; @(negedge clk); rd = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset values
    chk("R1 eoc", eoc, 0); chk("R1 ovr", ovr, 0);
    chk("R1 irq", irq, 0); chk("R1 result", result, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: start pulse with enable low, then enable without pulse
    fill(99);
    ord_sel = 3'd1; fosr_m1 = 10'd1; iosr_m1 = 8'd0;
    @(negedge clk); start = 1'b1; @(negedge clk); start = 1'b0;
    for (int n = 1; n <= 20; n++) drive_bit(bits[n], 0);
    chk("R2 start without enable", eoc, 0);
    en = 1'b1;
    for (int n = 1; n <= 20; n++) drive_bit(bits[n], 1);
    chk("R2 enable without start", eoc, 0);

    // R11: disable mid conversion kills it
    eoc_ie = 1'b1;
    do_start(1, 4, 3, 1'b0);
    for (int n = 1; n <= 6; n++) drive_bit(bits[n], 0);
    @(negedge clk); en = 1'b0; @(negedge clk); en = 1'b1;
    for (int n = 7; n <= 30; n++) drive_bit(bits[n], 0);
    chk("R11 stopped conversion", eoc, 0);

    // vector table: R3 R4 R5 R12 R13 timing and value, R8 R10 R7
    for (int v = 0; v < 7; v++) begin
      int code = VEC[v][0];
      int fo = VEC[v][1];
      int io = VEC[v][2];
      int nb = VEC[v][3];
      string tg = (code == 0) ? "R4" : "R3";
      fill(v + 1);
      do_start(code, fo, io, 1'b0);
      for (int n = 1; n <= nb; n++) begin
        drive_bit(bits[n], n % 3);
        if (n == nb - 1) chk({tg, " R12 no result one bit early"}, eoc, 0);
      end
      chk({tg, " R13 result flagged at settle count"}, eoc, 1);
      chk("R5 result value", longint'($signed(result)),
          model_res(code, fo, io, (code == 0) ? 4 : code));
      chk("R10 irq with eoc enabled", irq, 1);
      pulse_rd();
      chk("R8 rd clears eoc", eoc, 0);
      chk("R10 irq drops", irq, 0);
      for (int n = nb + 1; n <= 3 * nb; n++) drive_bit(bits[n], 0);
      chk("R7 single mode idle", eoc, 0);
    end

    // R6 R9: continuous, overrun, clear
    eoc_ie = 1'b0; ovr_ie = 1'b1;
    fill(11);
    do_start(3, 2, 2, 1'b1);
    for (int n = 1; n <= 11; n++) drive_bit(bits[n], 0);
    chk("R6 first continuous result", eoc, 1);
    chk("R5 first continuous value", longint'($signed(result)), model_res(3, 2, 2, 3));
    chk("R10 irq masked eoc", irq, 0);
    for (int n = 12; n <= 14; n++) drive_bit(bits[n], 1);
    chk("R9 no overrun yet", ovr, 0);
    drive_bit(bits[15], 0);
    chk("R9 overrun on unread", ovr, 1);
    chk("R6 second value", longint'($signed(result)), model_res(3, 2, 2, 5));
    chk("R10 irq from overrun", irq, 1);
    pulse_rd();
    chk("R8 eoc cleared", eoc, 0);
    chk("R9 ovr kept after rd", ovr, 1);
    @(negedge clk); ovr_clr = 1'b1; @(negedge clk); ovr_clr = 1'b0;
    chk("R9 ovr cleared", ovr, 0);
    chk("R10 irq quiet", irq, 0);
    for (int n = 16; n <= 18; n++) drive_bit(bits[n], 2);
    chk("R6 no early third result", eoc, 0);
    drive_bit(bits[19], 0);
    chk("R6 third result period", eoc, 1);
    chk("R6 third value", longint'($signed(result)), model_res(3, 2, 2, 7));
    chk("R9 no overrun after read", ovr, 0);
    @(negedge clk); en = 1'b0;
    repeat (2) @(negedge clk);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule